// File: doc/BRIEF.md
# Dual-Channel Interrupt Vector Logic

This block holds the interrupt state of a two-channel serial controller. Each channel (A and B) tracks a receive-pending flag, a transmit-pending flag and two under-service flags. From these, the block drives one registered interrupt request, a pending-bits register and a shared vector register for the host to read. The vector names the source that is being serviced. While one source of a channel is under service, a later source on that channel does not overwrite the vector, but its pending bit is still recorded.

Interrupt events and host commands arrive one at a time on a plain event port. The port has a valid strobe, a channel select and an operation code, and it has no back-pressure: every strobed event is applied in the cycle it is presented. The enables, the receive interrupt mode, the break status and the status-high vector mode are level inputs. They come from the register file that sits outside this block.

Top module: `ivec_ctrl`

## Requirements
- R1: After reset, irq is 0, the pending register is 0x00 and the vector is 0x06.
- R2: irq is registered. It goes high one cycle after any of these holds on either channel: the transmit enable is set and transmit is pending; the receive mode allows interrupts and receive is pending; or both the break enable and the break status are set. When none of these holds, irq is 0 one cycle later.
- R3: The receive mode field (2 bits per channel) allows receive interrupts only at the values 01 and 10. The values 00 and 11 never raise irq.
- R4: The pending register bits are: bit0 break on B, bit1 transmit B, bit2 receive B, bit3 break on A, bit4 transmit A, bit5 receive A. Bits 7:6 are always 0. A break bit is set while that channel has both break enable and break status, and it is registered one cycle after the inputs.
- R5: With status_hi low, the vector codes are: receive A 0x0C, transmit A 0x08, receive B 0x04, transmit B 0x00, none 0x06.
- R6: With status_hi high, the vector codes are: receive A 0x30, transmit A 0x10, receive B 0x20, none 0x60. Transmit B stays 0x00.
- R7: Operation codes on evt_op: 0 raise receive, 1 raise transmit, 2 clear receive, 3 clear transmit, 4 reset highest under service, 5 channel reset. evt_chan 0 selects A and 1 selects B. A raise always sets the pending bit. It loads the vector and marks the source under service only if the other source of the same channel is not under service.
- R8: Clearing a source drops its pending bit and its under-service flag, and sets the vector to the none code for the current mode.
- R9: If the other source of the same channel is still pending after a clear, it is raised again in the same cycle. It takes the service flag, and the vector shows its code.
- R10: Reset-highest-under-service clears receive if receive is under service, otherwise transmit if transmit is under service, and otherwise changes nothing.
- R11: Channel reset clears that channel's pending and service flags. Resetting B also sets the vector to the none code for the current mode. Resetting A leaves the vector as it is.
- R12: The vector code is chosen when the vector is written. Changing status_hi later does not change a stored vector.
- R13: Operation codes 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event strobe, applied in the same cycle |
| evt_chan | input | 1 | Event channel, 0 = A, 1 = B |
| evt_op | input | 3 | Operation code (see R7) |
| status_hi | input | 1 | Selects the high vector code set |
| tx_ie | input | 2 | Transmit interrupt enable, bit0 = A |
| rx_mode | input | 4 | Receive interrupt mode, [1:0] = A, [3:2] = B |
| brk_ie | input | 2 | Break interrupt enable, bit0 = A |
| brk_stat | input | 2 | Break status, bit0 = A |
| irq | output | 1 | Registered interrupt request |
| pend | output | 8 | Pending-bits register |
| vector | output | 8 | Interrupt vector register |

## Verification
The assertions check, on every cycle, the properties that hold regardless of the event sequence. Receive and transmit are never both under service on a channel. A source under service is always pending. The vector always holds one of the legal codes. irq follows an enabled pending source and drops when every enable is off. A channel reset or a service reset takes effect on the next cycle. Only the bench scenarios can show the order-dependent behaviour: the exact code in each mode, the blocked raise that leaves the vector alone, the re-raise after a clear, the vector that stays put across a later mode change, and the asymmetric effect of resetting A or B.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int VEC_W  = 8;
  localparam int PEND_W = 8;
  localparam int NCH    = 2;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_RX_SET  = 3'd0,
    OP_TX_SET  = 3'd1,
    OP_RX_CLR  = 3'd2,
    OP_TX_CLR  = 3'd3,
    OP_IUS_RST = 3'd4,
    OP_CH_RST  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    VK_NONE = 2'd0,
    VK_RX   = 2'd1,
    VK_TX   = 2'd2
  } vkind_e;

  localparam logic [VEC_W-1:0] VEC_RESET = 8'h06;

  function automatic logic [VEC_W-1:0] vec_code(input logic is_b, input vkind_e k,
                                                input logic hi);
    logic [VEC_W-1:0] v;
    case (k)
      VK_RX:   v = is_b ? (hi ? 8'h20 : 8'h04) : (hi ? 8'h30 : 8'h0C);
      VK_TX:   v = is_b ? 8'h00 : (hi ? 8'h10 : 8'h08);
      default: v = hi ? 8'h60 : 8'h06;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/ivec_chan.sv
module ivec_chan
  import ivec_pkg::*;
#(
  parameter bit IS_B = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_hit,
  input  logic [OP_W-1:0] op,
  output logic            rx_pend,
  output logic            tx_pend,
  output logic            rx_us,
  output logic            tx_us,
  output logic            vec_we,
  output vkind_e          vec_kind
);
  logic n_rx_pend, n_tx_pend, n_rx_us, n_tx_us;
  logic do_rx_clr, do_tx_clr;

  always_comb begin
    n_rx_pend = rx_pend;
    n_tx_pend = tx_pend;
    n_rx_us   = rx_us;
    n_tx_us   = tx_us;
    vec_we    = 1'b0;
    vec_kind  = VK_NONE;
    do_rx_clr = 1'b0;
    do_tx_clr = 1'b0;
    if (op_hit) begin
      case (op)
        OP_RX_SET: begin
          n_rx_pend = 1'b1;
          if (!tx_us) begin
            n_rx_us  = 1'b1;
            vec_we   = 1'b1;
            vec_kind = VK_RX;
          end
        end
        OP_TX_SET: begin
          n_tx_pend = 1'b1;
          if (!rx_us) begin
            n_tx_us  = 1'b1;
            vec_we   = 1'b1;
            vec_kind = VK_TX;
          end
        end
        OP_RX_CLR:  do_rx_clr = 1'b1;
        OP_TX_CLR:  do_tx_clr = 1'b1;
        OP_IUS_RST: begin
          do_rx_clr = rx_us;
          do_tx_clr = !rx_us && tx_us;
        end
        OP_CH_RST: begin
          n_rx_pend = 1'b0;
          n_tx_pend = 1'b0;
          n_rx_us   = 1'b0;
          n_tx_us   = 1'b0;
          vec_we    = IS_B;
          vec_kind  = VK_NONE;
        end
        default: ;
      endcase
      if (do_rx_clr) begin
        n_rx_pend = 1'b0;
        n_rx_us   = 1'b0;
        vec_we    = 1'b1;
        vec_kind  = VK_NONE;
        if (tx_pend) begin
          n_tx_us  = 1'b1;
          vec_kind = VK_TX;
        end
      end
      if (do_tx_clr) begin
        n_tx_pend = 1'b0;
        n_tx_us   = 1'b0;
        vec_we    = 1'b1;
        vec_kind  = VK_NONE;
        if (rx_pend) begin
          n_rx_us  = 1'b1;
          vec_kind = VK_RX;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_pend <= 1'b0;
      tx_pend <= 1'b0;
      rx_us   <= 1'b0;
      tx_us   <= 1'b0;
    end else begin
      rx_pend <= n_rx_pend;
      tx_pend <= n_tx_pend;
      rx_us   <= n_rx_us;
      tx_us   <= n_tx_us;
    end
  end

  // R7: both sources of a channel are never under service together
  a_r7_us_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_us && tx_us));
  // R8: a source under service is always pending
  a_r8_us_implies_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_us -> rx_pend) && (tx_us -> tx_pend));
  // R11: channel reset empties the channel's state on the next cycle
  a_r11_chan_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (op_hit && op == OP_CH_RST) |=> (!rx_pend && !tx_pend && !rx_us && !tx_us));
  // R10: service reset with receive under service releases receive
  a_r10_ius_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (op_hit && op == OP_IUS_RST && rx_us) |=> !rx_us);
endmodule

// File: rtl/ivec_vec.sv
module ivec_vec
  import ivec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             status_hi,
  input  logic             we_a,
  input  vkind_e           kind_a,
  input  logic             we_b,
  input  vkind_e           kind_b,
  output logic [VEC_W-1:0] vector
);
  always_ff @(posedge clk) begin
    if (!rst_n) vector <= VEC_RESET;
    else if (we_a) vector <= vec_code(1'b0, kind_a, status_hi);
    else if (we_b) vector <= vec_code(1'b1, kind_b, status_hi);
  end

  // R7: only one channel writes the shared vector in any cycle
  a_r7_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_a, we_b}));
  // R5/R6: the stored vector is always a legal code
  a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    vector inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60});
  // R12: vector holds when nobody writes it, whatever status_hi does
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_a && !we_b) |=> $stable(vector));
endmodule

// File: rtl/ivec_irq.sv
module ivec_irq
  import ivec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   rx_pend,
  input  logic [NCH-1:0]   tx_pend,
  input  logic [NCH-1:0]   tx_ie,
  input  logic [2*NCH-1:0] rx_mode,
  input  logic [NCH-1:0]   brk_ie,
  input  logic [NCH-1:0]   brk_stat,
  output logic [NCH-1:0]   ext_q,
  output logic             irq
);
  logic [NCH-1:0] src;
  logic [NCH-1:0] rx_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_src
    assign rx_ok[c] = (rx_mode[2*c+:2] == 2'b01) || (rx_mode[2*c+:2] == 2'b10);
    assign src[c]   = (tx_ie[c] && tx_pend[c]) || (rx_ok[c] && rx_pend[c]) ||
                      (brk_ie[c] && brk_stat[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      ext_q <= '0;
    end else begin
      irq   <= |src;
      ext_q <= brk_ie & brk_stat;
    end
  end

  // R2: an enabled pending transmit on A raises irq next cycle
  a_r2_tx_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ie[0] && tx_pend[0]) |=> irq);
  // R2/R3: with every enable off and receive modes closed, irq is low next cycle
  a_r3_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ie == '0 && brk_ie == '0 &&
     rx_mode[1:0] inside {2'b00, 2'b11} && rx_mode[3:2] inside {2'b00, 2'b11}) |=> !irq);
endmodule

// File: rtl/ivec_ctrl.sv
module ivec_ctrl
  import ivec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic              evt_chan,
  input  logic [2:0]        evt_op,
  input  logic              status_hi,
  input  logic [1:0]        tx_ie,
  input  logic [3:0]        rx_mode,
  input  logic [1:0]        brk_ie,
  input  logic [1:0]        brk_stat,
  output logic              irq,
  output logic [7:0]        pend,
  output logic [7:0]        vector
);
  logic [NCH-1:0] rx_pend, tx_pend, rx_us, tx_us, vec_we, ext_q;
  vkind_e         vec_kind [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ivec_chan #(.IS_B(c == 1)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_hit   (evt_valid && (evt_chan == c[0])),
      .op       (evt_op),
      .rx_pend  (rx_pend[c]),
      .tx_pend  (tx_pend[c]),
      .rx_us    (rx_us[c]),
      .tx_us    (tx_us[c]),
      .vec_we   (vec_we[c]),
      .vec_kind (vec_kind[c])
    );
  end

  ivec_vec u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_hi (status_hi),
    .we_a      (vec_we[0]),
    .kind_a    (vec_kind[0]),
    .we_b      (vec_we[1]),
    .kind_b    (vec_kind[1]),
    .vector    (vector)
  );

  ivec_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_pend  (rx_pend),
    .tx_pend  (tx_pend),
    .tx_ie    (tx_ie),
    .rx_mode  (rx_mode),
    .brk_ie   (brk_ie),
    .brk_stat (brk_stat),
    .ext_q    (ext_q),
    .irq      (irq)
  );

  assign pend = {2'b00, rx_pend[0], tx_pend[0], ext_q[0], rx_pend[1], tx_pend[1], ext_q[1]};

  // R4: the two top bits of the pending register never set
  a_r4_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pend[PEND_W-1:PEND_W-2] == 2'b00);
endmodule

// File: tb/tb_ivec_ctrl.sv
module tb_ivec_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_valid = 1'b0;
  logic       evt_chan = 1'b0;
  logic [2:0] evt_op = 3'd0;
  logic       status_hi = 1'b0;
  logic [1:0] tx_ie = 2'b00;
  logic [3:0] rx_mode = 4'b0000;
  logic [1:0] brk_ie = 2'b00;
  logic [1:0] brk_stat = 2'b00;
  logic       irq;
  logic [7:0] pend, vector;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ivec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_chan(evt_chan),
    .evt_op(evt_op), .status_hi(status_hi), .tx_ie(tx_ie), .rx_mode(rx_mode),
    .brk_ie(brk_ie), .brk_stat(brk_stat), .irq(irq), .pend(pend), .vector(vector)
  );

  localparam logic A = 1'b0, B = 1'b1;
  localparam logic [2:0] RXS = 3'd0, TXS = 3'd1, RXC = 3'd2, TXC = 3'd3,
                         IUS = 3'd4, CRS = 3'd5;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic op(input logic ch, input logic [2:0] code);
    @(negedge clk);
    evt_valid = 1'b1; evt_chan = ch; evt_op = code;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 pend", pend, 8'h00);
    check("R1 vector", vector, 8'h06);
  endtask

  task automatic t_tx_basic;
    tx_ie = 2'b01;
    op(A, TXS);
    check("R5 txA vector", vector, 8'h08);
    check("R4 txA pend", pend, 8'h10);
    @(negedge clk);
    check("R2 tx irq", {7'd0, irq}, 8'h01);
    op(A, TXC);
    check("R8 clear vector", vector, 8'h06);
    check("R8 clear pend", pend, 8'h00);
    @(negedge clk);
    check("R2 irq drops", {7'd0, irq}, 8'h00);
    tx_ie = 2'b00;
    op(B, TXS);
    check("R5 txB vector", vector, 8'h00);
    check("R4 txB pend", pend, 8'h02);
    @(negedge clk);
    check("R2 tx disabled irq", {7'd0, irq}, 8'h00);
    op(B, TXC);
  endtask

  task automatic t_rx_modes;
    op(B, RXS);
    check("R5 rxB vector", vector, 8'h04);
    check("R4 rxB pend", pend, 8'h04);
    for (int m = 0; m < 4; m++) begin
      rx_mode[3:2] = m[1:0];
      @(negedge clk);
      check("R3 rx mode irq", {7'd0, irq}, (m == 1 || m == 2) ? 8'h01 : 8'h00);
    end
    rx_mode = 4'b0000;
    op(B, RXC);
    check("R8 rxB clear", pend, 8'h00);
  endtask

  task automatic t_high;
    status_hi = 1'b1;
    op(A, RXS); check("R6 rxA hi", vector, 8'h30);
    op(A, RXC); check("R6 none hi", vector, 8'h60);
    op(B, RXS); check("R6 rxB hi", vector, 8'h20);
    op(B, RXC);
    op(A, TXS); check("R6 txA hi", vector, 8'h10);
    op(A, TXC);
    op(B, TXS); check("R6 txB hi", vector, 8'h00);
    op(B, TXC); check("R8 none hi", vector, 8'h60);
    status_hi = 1'b0;
    op(B, CRS); check("R11 B reset vector lo", vector, 8'h06);
  endtask

  task automatic t_block;
    op(A, TXS); check("R7 tx first", vector, 8'h08);
    op(A, RXS);
    check("R7 rx blocked vector", vector, 8'h08);
    check("R7 rx blocked pend", pend, 8'h30);
    op(A, IUS);
    check("R10 ius clears tx, R9 rx raised", vector, 8'h0C);
    check("R10 ius pend", pend, 8'h20);
    op(A, IUS);
    check("R10 ius clears rx", vector, 8'h06);
    check("R10 ius pend empty", pend, 8'h00);
    op(A, RXS); op(A, TXS);
    check("R7 tx blocked vector", vector, 8'h0C);
    op(A, RXC);
    check("R9 tx re-raised", vector, 8'h08);
    check("R9 pend", pend, 8'h10);
    op(A, TXC);
    op(B, TXS);
    op(A, IUS);
    check("R10 ius no-op vector", vector, 8'h00);
    check("R10 ius no-op pend", pend, 8'h02);
    op(B, IUS);
    check("R10 ius B tx", vector, 8'h06);
    check("R10 ius B pend", pend, 8'h00);
  endtask

  task automatic t_break;
    @(negedge clk);
    brk_stat = 2'b01;
    @(negedge clk);
    check("R2 break without enable", {7'd0, irq}, 8'h00);
    check("R4 break without enable pend", pend, 8'h00);
    brk_ie = 2'b01;
    @(negedge clk);
    check("R2 break irq", {7'd0, irq}, 8'h01);
    check("R4 breakA pend", pend, 8'h08);
    brk_ie = 2'b10; brk_stat = 2'b10;
    @(negedge clk);
    check("R4 breakB pend", pend, 8'h01);
    brk_ie = 2'b00; brk_stat = 2'b00;
    @(negedge clk);
    check("R2 break off irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_chrst;
    op(A, RXS); op(B, TXS);
    check("R11 setup", pend, 8'h22);
    op(A, CRS);
    check("R11 A reset pend", pend, 8'h02);
    check("R11 A reset keeps vector", vector, 8'h00);
    op(B, CRS);
    check("R11 B reset pend", pend, 8'h00);
    check("R11 B reset vector", vector, 8'h06);
  endtask

  task automatic t_capture;
    status_hi = 1'b1;
    op(A, RXS);
    check("R12 hi code", vector, 8'h30);
    status_hi = 1'b0;
    @(negedge clk);
    check("R12 kept after mode change", vector, 8'h30);
    op(A, RXC);
    check("R12 clear in lo", vector, 8'h06);
  endtask

  task automatic t_unused;
    op(A, TXS);
    op(A, 3'd6);
    op(A, 3'd7);
    check("R13 vector", vector, 8'h08);
    check("R13 pend", pend, 8'h10);
    op(A, TXC);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_rx_modes();
    t_high();
    t_block();
    t_break();
    t_chrst();
    t_capture();
    t_unused();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule